// File: doc/BRIEF.md
# Byte-Serial Status Packet Generator

This block turns a parallel status word into a short packet on an 8-bit byte lane. When a packet is due it freezes the status word together with a software-set sequence tag, raises a request, and waits for the downstream receiver to acknowledge the first byte. That first byte is a fixed address that identifies this status source. The receiver then takes the remaining bytes, one per clock, with no further handshake.

Software configures the block with one 8-bit control write. The write sets a 6-bit sequence tag that travels in the packet, so software can match a report to the write that caused it. It also selects when packets are sent: never, once, whenever the status changes, or back to back. The packet grows with the status width. The first payload byte carries the sequence tag and the two lowest status bits, and the remaining status bits follow in groups of eight.

Top module: `stat_pkt_gen`

## Requirements
- R1: After either reset `pkt_req` is 0, `pkt_ad` is 0 and the reporting mode is off.
- R2: A packet is, in byte order: `ADDR_BYTE`, then {tag[5:0], status[1:0]} (tag in bits 7:2), then status[9:2], status[17:10] and status[25:18], each with the lowest status bit in bit 0 and unused high bits zero. Outside a packet `pkt_ad` is 0.
- R3: The packet is 2 + ceil((PAYLOAD_BITS-2)/8) bytes long, which is 4 bytes for the default of 15 bits.
- R4: While `pkt_req` is 1 and `pkt_ack` is 0, the request stays high and `pkt_ad` holds the address byte. `pkt_ack` has no effect when no request is pending.
- R5: `pkt_req` is 0 in the cycle after the one in which `pkt_ack` is seen. The remaining bytes appear on the consecutive cycles after the acknowledge cycle.
- R6: The status word and the tag are captured on the edge that raises `pkt_req`. Later status changes do not alter a packet in flight.
- R7: A control write loads the tag from `ctl_data[5:0]` and the mode from `ctl_data[7:6]`: 0 off, 1 send once, 2 send on status change, 3 send continuously.
- R8: In send-once mode exactly one packet is sent, and the mode then returns to off.
- R9: In on-change mode a request is raised only when the status differs from the last status captured. That value is 0 after reset.
- R10: In off mode no request is raised. In continuous mode each new request rises two cycles after the last byte of the previous packet.
- R11: `srst` resets the block on the next clock edge. `arst` resets it at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| srst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control word: mode in [7:6], tag in [5:0] |
| status | input | PAYLOAD_BITS | Parallel status word |
| pkt_ad | output | 8 | Packet byte lane |
| pkt_req | output | 1 | Packet request |
| pkt_ack | input | 1 | Receiver takes the address byte in this cycle |

## Verification
A trigger seen in an idle cycle raises `pkt_req` one cycle later. The three bytes after the address arrive in the first, second and third cycles after the acknowledge cycle. In continuous mode the next request comes two cycles after the last byte. The bench drives its inputs and the acknowledge just after the falling edge and samples one time step later. Because of this, every comparison sees the values the design registered on the preceding rising edge. A queue of expected bytes is compared in order against those sampled cycles, and the continuous-mode gap is measured in rising-edge counts.

// File: rtl/stat_pkt_pkg.sv
`timescale 1ns/1ps
package stat_pkt_pkg;
   localparam int TAG_W = 6;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_ONCE = 2'd1,
      MODE_AUTO = 2'd2,
      MODE_CONT = 2'd3
   } rpt_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_SEND
   } ser_state_t;

   // bytes in one packet: address, tag byte, then the remaining status bits by eight
   function automatic int pkt_bytes(input int pbits);
      return 2 + (pbits - 2 + 7) / 8;
   endfunction
endpackage

// File: rtl/stat_pkt_cfg.sv
`timescale 1ns/1ps
module stat_pkt_cfg
   import stat_pkt_pkg::*;
(
   input  logic             clk,
   input  logic             arst,
   input  logic             srst,
   input  logic             ctl_we,
   input  logic [7:0]       ctl_data,
   input  logic             start,
   output rpt_mode_t        mode,
   output logic [TAG_W-1:0] tag
);
   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         mode <= MODE_OFF;
         tag  <= '0;
      end else if (srst) begin
         mode <= MODE_OFF;
         tag  <= '0;
      end else if (ctl_we) begin
         mode <= rpt_mode_t'(ctl_data[7:6]);
         tag  <= ctl_data[TAG_W-1:0];
      end else if (start && mode == MODE_ONCE) begin
         mode <= MODE_OFF;
      end
   end
endmodule

// File: rtl/stat_pkt_pack.sv
`timescale 1ns/1ps
module stat_pkt_pack
   import stat_pkt_pkg::*;
#(
   parameter int         PAYLOAD_BITS = 15,
   parameter logic [7:0] ADDR_BYTE    = 8'h3C,
   localparam int        NB           = pkt_bytes(PAYLOAD_BITS),
   localparam int        FRAME_W      = 8 * NB
)(
   input  logic [PAYLOAD_BITS-1:0] status,
   input  logic [TAG_W-1:0]        tag,
   output logic [FRAME_W-1:0]      frame
);
   assign frame[7:0]  = ADDR_BYTE;
   assign frame[15:8] = {tag, status[1:0]};

   generate
      if (NB > 2) begin : g_ext
         localparam int EXT_W = 8 * (NB - 2);
         logic [EXT_W-1:0] ext;
         always_comb begin
            ext = '0;
            ext[PAYLOAD_BITS-3:0] = status[PAYLOAD_BITS-1:2];
         end
         assign frame[FRAME_W-1:16] = ext;
      end
   endgenerate
endmodule

// File: rtl/stat_pkt_ser.sv
`timescale 1ns/1ps
module stat_pkt_ser
   import stat_pkt_pkg::*;
#(
   parameter int         PAYLOAD_BITS = 15,
   parameter logic [7:0] ADDR_BYTE    = 8'h3C,
   localparam int        NB           = pkt_bytes(PAYLOAD_BITS),
   localparam int        FRAME_W      = 8 * NB,
   localparam int        CW           = $clog2(NB + 1)
)(
   input  logic                    clk,
   input  logic                    arst,
   input  logic                    srst,
   input  rpt_mode_t               mode,
   input  logic [PAYLOAD_BITS-1:0] status,
   input  logic [FRAME_W-1:0]      frame,
   input  logic                    ack,
   output logic                    start,
   output logic                    req,
   output logic [7:0]              ad
);
   ser_state_t              state;
   logic [FRAME_W-1:0]      shreg;
   logic [CW-1:0]           left;
   logic [PAYLOAD_BITS-1:0] last_sent;
   logic                    due;

   always_comb begin
      case (mode)
         MODE_ONCE, MODE_CONT: due = 1'b1;
         MODE_AUTO:            due = (status != last_sent);
         default:              due = 1'b0;
      endcase
   end

   assign start = (state == ST_IDLE) && due;
   assign req   = (state == ST_REQ);
   assign ad    = (state == ST_IDLE) ? 8'h00 : shreg[7:0];

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         left      <= '0;
         last_sent <= '0;
      end else if (srst) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         left      <= '0;
         last_sent <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               shreg     <= frame;
               last_sent <= status;
               state     <= ST_REQ;
            end
            ST_REQ: if (ack) begin
               shreg <= shreg >> 8;
               left  <= CW'(NB - 1);
               state <= ST_SEND;
            end
            default: begin
               shreg <= shreg >> 8;
               left  <= left - 1'b1;
               if (left == CW'(1)) state <= ST_IDLE;
            end
         endcase
      end
   end

   p_addr_r2: assert property (@(posedge clk) disable iff (arst || srst)
      req |-> (ad == ADDR_BYTE));
   p_hold_r4: assert property (@(posedge clk) disable iff (arst || srst)
      (req && !ack) |=> (req && $stable(ad)));
   p_drop_r5: assert property (@(posedge clk) disable iff (arst || srst)
      (req && ack) |=> !req);
endmodule

// File: rtl/stat_pkt_gen.sv
`timescale 1ns/1ps
module stat_pkt_gen
   import stat_pkt_pkg::*;
#(
   parameter int         PAYLOAD_BITS = 15,
   parameter logic [7:0] ADDR_BYTE    = 8'h3C
)(
   input  logic                    clk,
   input  logic                    arst,
   input  logic                    srst,
   input  logic                    ctl_we,
   input  logic [7:0]              ctl_data,
   input  logic [PAYLOAD_BITS-1:0] status,
   output logic [7:0]              pkt_ad,
   output logic                    pkt_req,
   input  logic                    pkt_ack
);
   localparam int NB = pkt_bytes(PAYLOAD_BITS);

   generate
      if (PAYLOAD_BITS < 2 || PAYLOAD_BITS > 26) begin : g_bad_width
         $error("stat_pkt_gen: PAYLOAD_BITS must lie in 2..26");
      end
   endgenerate

   rpt_mode_t          mode;
   logic [TAG_W-1:0]   tag;
   logic               start;
   logic [8*NB-1:0]    frame;

   stat_pkt_cfg u_cfg (
      .clk(clk), .arst(arst), .srst(srst),
      .ctl_we(ctl_we), .ctl_data(ctl_data), .start(start),
      .mode(mode), .tag(tag)
   );

   stat_pkt_pack #(.PAYLOAD_BITS(PAYLOAD_BITS), .ADDR_BYTE(ADDR_BYTE)) u_pack (
      .status(status), .tag(tag), .frame(frame)
   );

   stat_pkt_ser #(.PAYLOAD_BITS(PAYLOAD_BITS), .ADDR_BYTE(ADDR_BYTE)) u_ser (
      .clk(clk), .arst(arst), .srst(srst), .mode(mode), .status(status),
      .frame(frame), .ack(pkt_ack), .start(start), .req(pkt_req), .ad(pkt_ad)
   );

   p_once_off_r8: assert property (@(posedge clk) disable iff (arst || srst)
      (start && mode == MODE_ONCE && !ctl_we) |=> (mode == MODE_OFF));
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (arst || srst)
      (mode == MODE_OFF && !ctl_we && !pkt_req) |=> !pkt_req);
endmodule

// File: tb/stat_pkt_gen_bench.sv
`timescale 1ns/1ps
module stat_pkt_gen_bench;
   localparam int         P    = 15;
   localparam logic [7:0] ADDR = 8'h3C;
   localparam int         NB   = 2 + (P - 2 + 7) / 8;

   logic         clk = 0;
   logic         arst = 1, srst = 0, ctl_we = 0, pkt_ack = 0;
   logic [7:0]   ctl_data = 0;
   logic [P-1:0] status = 0;
   logic [7:0]   pkt_ad;
   logic         pkt_req;

   stat_pkt_gen #(.PAYLOAD_BITS(P), .ADDR_BYTE(ADDR)) u_stat_pkt_gen (
      .clk(clk), .arst(arst), .srst(srst), .ctl_we(ctl_we), .ctl_data(ctl_data),
      .status(status), .pkt_ad(pkt_ad), .pkt_req(pkt_req), .pkt_ack(pkt_ack)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, last_cyc = 0, pkts_done = 0, req_rises = 0;
   int ack_lat = 0, waitc = 0;
   bit ack_en = 0, gap_chk = 0;
   logic [7:0] expq[$];

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // expected packet per R2/R3
   task automatic push_pkt(input logic [P-1:0] st, input logic [5:0] tg);
      logic [8*NB-1:0] f;
      f = '0;
      f[7:0]  = ADDR;
      f[15:8] = {tg, st[1:0]};
      for (int i = 2; i < P; i++) f[16 + i - 2] = st[i];
      for (int b = 0; b < NB; b++) expq.push_back(f[8*b +: 8]);
   endtask

   task automatic ctl_write(input logic [7:0] d);
      @(negedge clk); #2;
      ctl_we = 1; ctl_data = d;
      @(posedge clk); #2;
      ctl_we = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) cyc++;

   // acknowledge responder
   always @(negedge clk) begin
      if (ack_en) begin
         if (pkt_req && !pkt_ack) begin
            if (waitc >= ack_lat) begin pkt_ack = 1; waitc = 0; end
            else waitc++;
         end else begin
            pkt_ack = 0;
         end
      end
   end

   // monitor: pops expected bytes as the packet goes out
   initial begin
      int  rem;
      bit  prev_req;
      logic [7:0] e;
      rem = 0; prev_req = 0;
      forever begin
         @(negedge clk); #1;
         if (arst || srst) begin
            rem = 0; prev_req = 0;
         end else begin
            if (pkt_req && !prev_req) begin
               req_rises++;
               if (gap_chk) chk("R10 continuous gap", cyc - last_cyc, 2);
            end
            if (pkt_req && pkt_ack) begin
               if (expq.size() == 0) chk("R2 unexpected packet", 1, 0);
               else begin e = expq.pop_front(); chk("R2 address byte", pkt_ad, e); end
               rem = NB - 1;
            end else if (rem > 0) begin
               if (expq.size() == 0) chk("R3 extra byte", 1, 0);
               else begin e = expq.pop_front(); chk("R2/R5 payload byte", pkt_ad, e); end
               rem--;
               if (rem == 0) begin pkts_done++; last_cyc = cyc; end
            end else if (!pkt_req) begin
               chk("R2 idle lane", pkt_ad, 0);
            end
            prev_req = pkt_req;
         end
      end
   end

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(2); #2;
      arst = 0;
      idle(1); #2;
      chk("R1 req after reset", pkt_req, 0);
      chk("R1 lane after reset", pkt_ad, 0);

      // off mode: no request
      status = 15'h1111;
      idle(20);
      chk("R10 off mode quiet", req_rises, 0);

      // ack with nothing pending
      #2 pkt_ack = 1;
      idle(3); #2;
      chk("R4 ack ignored req", pkt_req, 0);
      chk("R4 ack ignored lane", pkt_ad, 0);
      pkt_ack = 0;

      // send once, with status changing while in flight
      ack_en = 1; ack_lat = 4;
      status = 15'h1234;
      push_pkt(15'h1234, 6'h2A);
      ctl_write(8'h6A);
      wait (pkt_req);
      @(negedge clk); #2 status = 15'h7777;
      wait (pkts_done == 1);
      idle(30);
      chk("R8 single packet", req_rises, 1);
      chk("R6 capture queue", expq.size(), 0);

      // on-change mode
      status = 15'h1234;
      ctl_write(8'h85);
      idle(20);
      chk("R9 unchanged no request", req_rises, 1);
      push_pkt(15'h7ABC, 6'h05);
      status = 15'h7ABC;
      wait (pkts_done == 2);
      idle(20);
      chk("R9 one packet per change", req_rises, 2);
      push_pkt(15'h0003, 6'h05);
      status = 15'h0003;
      wait (pkts_done == 3);
      idle(20);
      chk("R9 second change", req_rises, 3);
      ctl_write(8'h00);

      // continuous mode with immediate ack
      ack_lat = 0;
      status = 15'h5A5A;
      for (int k = 0; k < 3; k++) push_pkt(15'h5A5A, 6'h3F);
      ctl_write(8'hFF);
      wait (pkts_done == 4);
      gap_chk = 1;
      wait (pkts_done == 6);
      ctl_we = 1; ctl_data = 8'h00;
      @(posedge clk); #2 ctl_we = 0;
      gap_chk = 0;
      idle(20);
      chk("R10 continuous count", req_rises, 6);
      chk("R7 queue drained", expq.size(), 0);

      // synchronous reset mid-request
      ack_en = 0;
      ctl_write(8'hC0);
      wait (pkt_req);
      @(negedge clk); #2 srst = 1;
      @(posedge clk); #2 srst = 0;
      chk("R11 srst req", pkt_req, 0);
      chk("R11 srst lane", pkt_ad, 0);
      idle(20);
      chk("R11 srst mode off", req_rises, 7);

      // asynchronous reset mid-request
      ctl_write(8'hC0);
      wait (pkt_req);
      @(negedge clk); #3 arst = 1;
      #1 chk("R11 arst immediate", pkt_req, 0);
      @(negedge clk); #2 arst = 0;
      idle(20);
      chk("R11 arst mode off", req_rises, 8);
      chk("R1 lane after arst", pkt_ad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule